// File: doc/BRIEF.md
# Interrupt controller register interface

This block is the 32-bit memory-mapped register front end of a per-processor interrupt controller. It receives an access as a byte offset inside a 4 KB window (the window base is a parameter and never reaches the block) together with a write flag, an access size and write data. One cycle later it returns a response: read data and an error flag. It holds the identification, priority, destination, spurious-vector, error-status, divider and local-vector-table registers with fixed reset values. It also holds the 256-bit enable array and the two timer count registers.

The 256-bit request, in-service and trigger-mode arrays belong to the priority core. They enter the block as plain vectors and can be read as eight 32-bit words each. A write to the end-of-interrupt offset or to the timer initial-count offset is an action: the block raises a one-cycle strobe in the same cycle as the response. A global enable input gates the whole window. While that input is low, every access is refused with an error and changes nothing.

Top module: `lic_regfile`

## Requirements
- R1: After reset these registers read back their reset values. Version (0x030) is 0x80050010. Destination format (0x0E0) is 0xFFFFFFFF. Spurious vector (0x0F0) is 0x000000FF. Each of the six local vector entries at 0x320, 0x330, 0x340, 0x350, 0x360 and 0x370 is 0x00010000. All 256 enable bits are 1. Every other stored register and both timer counts are 0.
- R2: Each cycle with `acc_valid` high produces exactly one cycle of `rsp_valid` on the following cycle, carrying `rsp_rdata` and `rsp_err`. There is no response without an access.
- R3: While `ctl_enable` is 0, every access returns `rsp_err`=1 with data 0. It changes no stored state and raises no strobe.
- R4: The in-service, trigger-mode and request vectors can be read as word k at 0x100+0x10·k, 0x180+0x10·k and 0x200+0x10·k respectively. Word k returns bits [32k+31:32k]. Writes there are dropped without an error.
- R5: The enable array is read and written as word k at 0x480+0x10·k (bits [32k+31:32k]) and drives `ier_mask`.
- R6: Writes to the read-only offsets 0x030, 0x090, 0x0A0, 0x0C0 and 0x400 are dropped without an error, and those registers keep their values.
- R7: `acc_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = reserved. A write of any size other than 4 bytes is an error and has no effect. A 1-byte read returns byte lane `acc_offset[1:0]` zero-extended. A 4-byte read returns the whole word. A 2-byte or reserved-size read is an error.
- R8: A 4-byte write to 0x0B0 raises `eoi_pulse` for one cycle, without an error, and stores nothing. A read of 0x0B0 returns 0 without an error.
- R9: A write to 0x380 loads both `tmr_count_init` and `tmr_count_cur` and raises `tmr_load_pulse` in the same cycle. A write to 0x390 loads only the current count. Reads of these offsets return the respective counts.
- R10: The following accesses return data 0 with `rsp_err`=1: a read or write of an undecoded offset, a read or write of 0x300, 0x310, 0x410 or 0x420, a read of 0x400, and a write whose offset is not word aligned.
- R11: The registers at 0x020, 0x080, 0x0D0, 0x0E0, 0x0F0, 0x280 and 0x3E0, the six local vector entries and the four extended vector entries at 0x500–0x530 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_enable | input | 1 | Global enable; when low, all accesses are refused |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| acc_offset | input | 12 | Byte offset inside the 4 KB window |
| acc_wdata | input | 32 | Write data |
| isr_bits | input | 256 | In-service vector from the priority core |
| tmr_bits | input | 256 | Trigger-mode vector from the priority core |
| irr_bits | input | 256 | Request vector from the priority core |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Access refused or malformed |
| ier_mask | output | 256 | Enable array |
| eoi_pulse | output | 1 | End-of-interrupt strobe |
| tmr_load_pulse | output | 1 | Timer initial-count load strobe |
| tmr_count_init | output | 32 | Timer initial count |
| tmr_count_cur | output | 32 | Timer current count |

## Verification
Two pairs of effects can fall in the same cycle, and the bench checks each pair together. The first is a timer reload: the load strobe, the new initial count and the new current count must all appear with the response to the write. The bench samples all three in that one cycle and again after a later current-count-only write, which must leave the initial count alone. The second pair is the enable gate against an action write. The bench issues an end-of-interrupt write and an enable-array write while the gate is closed. It expects an error and no strobe in the response cycle, then reopens the gate and reads the enable word back unchanged.

// File: rtl/lic_pkg.sv
package lic_pkg;

   localparam int WORD_W   = 32;
   localparam int N_SCALAR = 7;   // id, task prio, logical dest, dest fmt, spurious, err status, divider
   localparam int N_LVT    = 6;
   localparam int N_XLVT   = 4;
   localparam logic [WORD_W-1:0] LVT_RST = 32'h0001_0000;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;

   typedef enum logic [3:0] {
      RK_NONE, RK_CONST, RK_SCALAR, RK_LVT, RK_XLVT,
      RK_ISR, RK_TMR, RK_IRR, RK_IER, RK_EOI,
      RK_TINIT, RK_TCUR, RK_FEAT, RK_CMD
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e  kind;
      logic [2:0] idx;
   } dec_t;

   // reset value of scalar slot i
   function automatic logic [WORD_W-1:0] scalar_rst(input int i);
      case (i)
         3:       return 32'hFFFF_FFFF;
         4:       return 32'h0000_00FF;
         default: return '0;
      endcase
   endfunction

   // fixed read-only values: 0 version, 1 arbitration, 2 processor prio, 3 remote read
   function automatic logic [WORD_W-1:0] const_val(input logic [2:0] i);
      return (i == 3'd0) ? 32'h8005_0010 : '0;
   endfunction

   // kinds that a well-formed write accepts (stored, action, or dropped)
   function automatic logic kind_writable(input reg_kind_e k);
      return !(k inside {RK_NONE, RK_CMD});
   endfunction

   // kinds that a read refuses
   function automatic logic kind_read_bad(input reg_kind_e k);
      return k inside {RK_NONE, RK_CMD, RK_FEAT};
   endfunction

endpackage

// File: rtl/lic_decode.sv
module lic_decode
   import lic_pkg::*;
#(
   parameter int OFF_W = 12
) (
   input  logic [OFF_W-1:0] off,
   output dec_t             dec
);

   logic [7:0] blk;
   assign blk = off[11:4];

   always_comb begin
      dec.kind = RK_NONE;
      dec.idx  = '0;
      if (off[3:2] == 2'b00) begin
         casez (blk)
            8'h02: begin dec.kind = RK_SCALAR; dec.idx = 3'd0; end
            8'h03: begin dec.kind = RK_CONST;  dec.idx = 3'd0; end
            8'h08: begin dec.kind = RK_SCALAR; dec.idx = 3'd1; end
            8'h09: begin dec.kind = RK_CONST;  dec.idx = 3'd1; end
            8'h0A: begin dec.kind = RK_CONST;  dec.idx = 3'd2; end
            8'h0B:       dec.kind = RK_EOI;
            8'h0C: begin dec.kind = RK_CONST;  dec.idx = 3'd3; end
            8'h0D: begin dec.kind = RK_SCALAR; dec.idx = 3'd2; end
            8'h0E: begin dec.kind = RK_SCALAR; dec.idx = 3'd3; end
            8'h0F: begin dec.kind = RK_SCALAR; dec.idx = 3'd4; end
            8'b0001_0???: begin dec.kind = RK_ISR; dec.idx = blk[2:0]; end
            8'b0001_1???: begin dec.kind = RK_TMR; dec.idx = blk[2:0]; end
            8'b0010_0???: begin dec.kind = RK_IRR; dec.idx = blk[2:0]; end
            8'h28: begin dec.kind = RK_SCALAR; dec.idx = 3'd5; end
            8'h30, 8'h31: dec.kind = RK_CMD;
            8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37: begin
               dec.kind = RK_LVT;
               dec.idx  = blk[2:0] - 3'd2;
            end
            8'h38:       dec.kind = RK_TINIT;
            8'h39:       dec.kind = RK_TCUR;
            8'h3E: begin dec.kind = RK_SCALAR; dec.idx = 3'd6; end
            8'h40:       dec.kind = RK_FEAT;
            8'h41, 8'h42: dec.kind = RK_CMD;
            8'b0100_1???: begin dec.kind = RK_IER; dec.idx = blk[2:0]; end
            8'b0101_00??: begin dec.kind = RK_XLVT; dec.idx = {1'b0, blk[1:0]}; end
            default:     dec.kind = RK_NONE;
         endcase
      end
   end

endmodule

// File: rtl/lic_store.sv
module lic_store
   import lic_pkg::*;
#(
   parameter int ARR_WORDS = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  dec_t                          dec,
   input  logic [WORD_W-1:0]             wdata,
   output logic [N_SCALAR*WORD_W-1:0]    scalar_q,
   output logic [N_LVT*WORD_W-1:0]       lvt_q,
   output logic [N_XLVT*WORD_W-1:0]      xlvt_q,
   output logic [ARR_WORDS*WORD_W-1:0]   ier_q,
   output logic [WORD_W-1:0]             tinit_q,
   output logic [WORD_W-1:0]             tcur_q
);

   genvar gi;

   generate
      for (gi = 0; gi < N_SCALAR; gi++) begin : g_scalar
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               scalar_q[gi*WORD_W +: WORD_W] <= scalar_rst(gi);
            else if (wr_en && dec.kind == RK_SCALAR && dec.idx == 3'(gi))
               scalar_q[gi*WORD_W +: WORD_W] <= wdata;
         end
      end

      for (gi = 0; gi < N_LVT; gi++) begin : g_lvt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lvt_q[gi*WORD_W +: WORD_W] <= LVT_RST;
            else if (wr_en && dec.kind == RK_LVT && dec.idx == 3'(gi))
               lvt_q[gi*WORD_W +: WORD_W] <= wdata;
         end
      end

      for (gi = 0; gi < N_XLVT; gi++) begin : g_xlvt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               xlvt_q[gi*WORD_W +: WORD_W] <= '0;
            else if (wr_en && dec.kind == RK_XLVT && dec.idx == 3'(gi))
               xlvt_q[gi*WORD_W +: WORD_W] <= wdata;
         end
      end

      for (gi = 0; gi < ARR_WORDS; gi++) begin : g_ier
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ier_q[gi*WORD_W +: WORD_W] <= '1;
            else if (wr_en && dec.kind == RK_IER && dec.idx == 3'(gi))
               ier_q[gi*WORD_W +: WORD_W] <= wdata;
         end
      end
   endgenerate

   // a reload writes both counts in the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tinit_q <= '0;
         tcur_q  <= '0;
      end else if (wr_en) begin
         if (dec.kind == RK_TINIT) begin
            tinit_q <= wdata;
            tcur_q  <= wdata;
         end else if (dec.kind == RK_TCUR) begin
            tcur_q  <= wdata;
         end
      end
   end

endmodule

// File: rtl/lic_rdmux.sv
module lic_rdmux
   import lic_pkg::*;
#(
   parameter int VEC_N     = 256,
   parameter int ARR_WORDS = 8
) (
   input  dec_t                          dec,
   input  logic [1:0]                    lane,
   input  logic [1:0]                    size,
   input  logic [N_SCALAR*WORD_W-1:0]    scalar_q,
   input  logic [N_LVT*WORD_W-1:0]       lvt_q,
   input  logic [N_XLVT*WORD_W-1:0]      xlvt_q,
   input  logic [ARR_WORDS*WORD_W-1:0]   ier_q,
   input  logic [WORD_W-1:0]             tinit_q,
   input  logic [WORD_W-1:0]             tcur_q,
   input  logic [VEC_N-1:0]              isr_bits,
   input  logic [VEC_N-1:0]              tmr_bits,
   input  logic [VEC_N-1:0]              irr_bits,
   output logic [WORD_W-1:0]             rd_data
);

   logic [WORD_W-1:0] word;
   int                sel;

   assign sel = int'(dec.idx) * WORD_W;

   always_comb begin
      case (dec.kind)
         RK_CONST:  word = const_val(dec.idx);
         RK_SCALAR: word = scalar_q[sel +: WORD_W];
         RK_LVT:    word = lvt_q[sel +: WORD_W];
         RK_XLVT:   word = xlvt_q[sel +: WORD_W];
         RK_IER:    word = ier_q[sel +: WORD_W];
         RK_ISR:    word = isr_bits[sel +: WORD_W];
         RK_TMR:    word = tmr_bits[sel +: WORD_W];
         RK_IRR:    word = irr_bits[sel +: WORD_W];
         RK_TINIT:  word = tinit_q;
         RK_TCUR:   word = tcur_q;
         default:   word = '0;
      endcase
   end

   always_comb begin
      if (size == SZ_BYTE)
         rd_data = {{(WORD_W-8){1'b0}}, word[int'(lane)*8 +: 8]};
      else
         rd_data = word;
   end

endmodule

// File: rtl/lic_regfile.sv
module lic_regfile
   import lic_pkg::*;
#(
   parameter logic [31:0] BASE_ADDR = 32'hFEE0_0000,
   parameter int          OFF_W     = 12,
   parameter int          VEC_N     = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctl_enable,
   input  logic               acc_valid,
   input  logic               acc_write,
   input  logic [1:0]         acc_size,
   input  logic [OFF_W-1:0]   acc_offset,
   input  logic [31:0]        acc_wdata,
   input  logic [VEC_N-1:0]   isr_bits,
   input  logic [VEC_N-1:0]   tmr_bits,
   input  logic [VEC_N-1:0]   irr_bits,
   output logic               rsp_valid,
   output logic [31:0]        rsp_rdata,
   output logic               rsp_err,
   output logic [VEC_N-1:0]   ier_mask,
   output logic               eoi_pulse,
   output logic               tmr_load_pulse,
   output logic [31:0]        tmr_count_init,
   output logic [31:0]        tmr_count_cur
);

   localparam int ARR_WORDS = VEC_N / WORD_W;
   localparam int WIN_BYTES = 1 << OFF_W;

   generate
      if (OFF_W != 12)
         $error("lic_regfile: the window must be 4 KB (OFF_W = 12)");
      if (ARR_WORDS * WORD_W != VEC_N || ARR_WORDS > 8)
         $error("lic_regfile: VEC_N must be a multiple of 32, at most 256");
      if ((BASE_ADDR % WIN_BYTES) != 0)
         $error("lic_regfile: BASE_ADDR must be aligned to the window");
   endgenerate

   dec_t                          dec;
   logic [N_SCALAR*WORD_W-1:0]    scalar_q;
   logic [N_LVT*WORD_W-1:0]       lvt_q;
   logic [N_XLVT*WORD_W-1:0]      xlvt_q;
   logic [WORD_W-1:0]             rd_data;
   logic                          wr_ok, rd_bad, acc_err, wr_commit;

   lic_decode #(.OFF_W(OFF_W)) u_dec (
      .off (acc_offset),
      .dec (dec)
   );

   // write is well formed: full word, aligned, at an offset that takes writes
   assign wr_ok     = (acc_size == SZ_WORD) && (acc_offset[1:0] == 2'b00) && kind_writable(dec.kind);
   assign rd_bad    = !(acc_size inside {SZ_BYTE, SZ_WORD}) || kind_read_bad(dec.kind);
   assign acc_err   = !ctl_enable || (acc_write ? !wr_ok : rd_bad);
   assign wr_commit = acc_valid && acc_write && !acc_err;

   lic_store #(.ARR_WORDS(ARR_WORDS)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_commit),
      .dec      (dec),
      .wdata    (acc_wdata),
      .scalar_q (scalar_q),
      .lvt_q    (lvt_q),
      .xlvt_q   (xlvt_q),
      .ier_q    (ier_mask),
      .tinit_q  (tmr_count_init),
      .tcur_q   (tmr_count_cur)
   );

   lic_rdmux #(.VEC_N(VEC_N), .ARR_WORDS(ARR_WORDS)) u_rd (
      .dec      (dec),
      .lane     (acc_offset[1:0]),
      .size     (acc_size),
      .scalar_q (scalar_q),
      .lvt_q    (lvt_q),
      .xlvt_q   (xlvt_q),
      .ier_q    (ier_mask),
      .tinit_q  (tmr_count_init),
      .tcur_q   (tmr_count_cur),
      .isr_bits (isr_bits),
      .tmr_bits (tmr_bits),
      .irr_bits (irr_bits),
      .rd_data  (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid      <= 1'b0;
         rsp_err        <= 1'b0;
         rsp_rdata      <= '0;
         eoi_pulse      <= 1'b0;
         tmr_load_pulse <= 1'b0;
      end else begin
         rsp_valid      <= acc_valid;
         rsp_err        <= acc_valid && acc_err;
         rsp_rdata      <= (acc_valid && !acc_write && !acc_err) ? rd_data : '0;
         eoi_pulse      <= wr_commit && (dec.kind == RK_EOI);
         tmr_load_pulse <= wr_commit && (dec.kind == RK_TINIT);
      end
   end

endmodule

// File: rtl/lic_regfile_chk.sv
module lic_regfile_chk #(
   parameter int OFF_W = 12,
   parameter int VEC_N = 256
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_enable,
   input logic             acc_valid,
   input logic [1:0]       acc_size,
   input logic             rsp_valid,
   input logic [31:0]      rsp_rdata,
   input logic             rsp_err,
   input logic [VEC_N-1:0] ier_mask,
   input logic             eoi_pulse,
   input logic             tmr_load_pulse,
   input logic [31:0]      tmr_count_init,
   input logic [31:0]      tmr_count_cur
);

   assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> rsp_valid);

   assert_no_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !rsp_valid);

   assert_disabled_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !ctl_enable) |=> (rsp_err && !eoi_pulse && !tmr_load_pulse));

   assert_disabled_ier_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !ctl_enable) |=> $stable(ier_mask));

   assert_byte_zext_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_size == 2'd0) |=> (rsp_rdata[31:8] == 24'd0));

   assert_eoi_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_pulse |-> (rsp_valid && !rsp_err));

   assert_load_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_load_pulse |-> (rsp_valid && !rsp_err && tmr_count_init == tmr_count_cur));

   assert_err_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_valid && rsp_rdata == 32'd0));

endmodule

bind lic_regfile lic_regfile_chk #(.OFF_W(OFF_W), .VEC_N(VEC_N)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .ctl_enable     (ctl_enable),
   .acc_valid      (acc_valid),
   .acc_size       (acc_size),
   .rsp_valid      (rsp_valid),
   .rsp_rdata      (rsp_rdata),
   .rsp_err        (rsp_err),
   .ier_mask       (ier_mask),
   .eoi_pulse      (eoi_pulse),
   .tmr_load_pulse (tmr_load_pulse),
   .tmr_count_init (tmr_count_init),
   .tmr_count_cur  (tmr_count_cur)
);

// File: tb/tb_lic_regfile.sv
`timescale 1ns/1ps
module tb_lic_regfile;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ctl_enable = 1'b1;
   logic         acc_valid = 1'b0;
   logic         acc_write = 1'b0;
   logic [1:0]   acc_size = 2'd2;
   logic [11:0]  acc_offset = '0;
   logic [31:0]  acc_wdata = '0;
   logic [255:0] isr_bits, tmr_bits, irr_bits;
   logic         rsp_valid, rsp_err, eoi_pulse, tmr_load_pulse;
   logic [31:0]  rsp_rdata, tmr_count_init, tmr_count_cur;
   logic [255:0] ier_mask;

   int tests = 0;
   int fails = 0;
   logic seen_eoi, seen_load;

   typedef struct {
      logic [31:0] data;
      logic        err;
      string       tag;
   } exp_t;
   exp_t sb[$];

   always #4 clk = ~clk;   // 125 MHz

   lic_regfile dut (.*);

   function automatic logic [31:0] pat(input logic [31:0] base, input int k);
      return base ^ (32'(k) * 32'h0101_0101);
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // driver: one access, expected response pushed to the scoreboard
   task automatic access(input logic wr, input logic [1:0] sz, input logic [11:0] off,
                         input logic [31:0] wd, input logic [31:0] ed, input logic ee,
                         input string tag);
      exp_t e;
      @(negedge clk);
      acc_valid = 1'b1; acc_write = wr; acc_size = sz; acc_offset = off; acc_wdata = wd;
      e.data = ed; e.err = ee; e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      acc_valid = 1'b0;
      seen_eoi  = eoi_pulse;
      seen_load = tmr_load_pulse;
   endtask

   // monitor: pops one expectation per response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R2 response without access", rsp_rdata, 32'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(rsp_rdata == e.data, {e.tag, " data"}, rsp_rdata, e.data);
            check(rsp_err == e.err, {e.tag, " err"}, 32'(rsp_err), 32'(e.err));
         end
      end
   end

   initial begin
      #(8 * 100000);
      check(1'b0, "watchdog expired", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int k = 0; k < 8; k++) begin
         isr_bits[k*32 +: 32] = pat(32'hA000_0001, k);
         tmr_bits[k*32 +: 32] = pat(32'h0B00_0020, k);
         irr_bits[k*32 +: 32] = pat(32'h00C0_0300, k);
      end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state at the ports
      check(ier_mask == '1, "R1 enable array reset", ier_mask[31:0], 32'hFFFF_FFFF);
      check(tmr_count_init == 0 && tmr_count_cur == 0, "R1 timer counts reset", tmr_count_cur, 32'd0);
      check(!rsp_valid && !eoi_pulse && !tmr_load_pulse, "R1 outputs idle", 32'(rsp_valid), 32'd0);
      access(0, 2'd2, 12'h030, 0, 32'h8005_0010, 0, "R1 version");
      access(0, 2'd2, 12'h0E0, 0, 32'hFFFF_FFFF, 0, "R1 dest format");
      access(0, 2'd2, 12'h0F0, 0, 32'h0000_00FF, 0, "R1 spurious");
      for (int i = 0; i < 6; i++)
         access(0, 2'd2, 12'(12'h320 + 16 * i), 0, 32'h0001_0000, 0, "R1 local vector entry");
      access(0, 2'd2, 12'h4F0, 0, 32'hFFFF_FFFF, 0, "R1 enable word 7");
      access(0, 2'd2, 12'h280, 0, 32'd0, 0, "R1 error status");

      // R2 no response in idle cycle
      @(negedge clk);
      check(!rsp_valid, "R2 idle cycle", 32'(rsp_valid), 32'd0);

      // R4 core vectors
      for (int k = 0; k < 8; k += 3) begin
         access(0, 2'd2, 12'(12'h100 + 16 * k), 0, pat(32'hA000_0001, k), 0, "R4 in-service word");
         access(0, 2'd2, 12'(12'h180 + 16 * k), 0, pat(32'h0B00_0020, k), 0, "R4 trigger word");
         access(0, 2'd2, 12'(12'h200 + 16 * k), 0, pat(32'h00C0_0300, k), 0, "R4 request word");
      end
      access(1, 2'd2, 12'h200, 32'h1234_5678, 0, 0, "R4 request write dropped");
      access(0, 2'd2, 12'h200, 0, pat(32'h00C0_0300, 0), 0, "R4 request unchanged");

      // R5 enable array
      access(1, 2'd2, 12'h480, 32'h0000_FF00, 0, 0, "R5 enable word 0 write");
      access(0, 2'd2, 12'h480, 0, 32'h0000_FF00, 0, "R5 enable word 0 read");
      access(1, 2'd2, 12'h4F0, 32'h8000_0001, 0, 0, "R5 enable word 7 write");
      check(ier_mask[31:0] == 32'h0000_FF00 && ier_mask[255:224] == 32'h8000_0001 &&
            ier_mask[223:32] == '1, "R5 ier_mask", ier_mask[255:224], 32'h8000_0001);

      // R6 read-only offsets
      access(1, 2'd2, 12'h030, 32'h0, 0, 0, "R6 version write dropped");
      access(0, 2'd2, 12'h030, 0, 32'h8005_0010, 0, "R6 version kept");
      access(1, 2'd2, 12'h0A0, 32'hFFFF_FFFF, 0, 0, "R6 proc prio write dropped");
      access(0, 2'd2, 12'h0A0, 0, 32'd0, 0, "R6 proc prio kept");
      access(1, 2'd2, 12'h400, 32'hFFFF_FFFF, 0, 0, "R6 feature write dropped");

      // R7 sizes and byte lanes; R11 stored registers
      access(1, 2'd0, 12'h080, 32'hDEAD_BEEF, 0, 1, "R7 byte write refused");
      access(0, 2'd2, 12'h080, 0, 32'd0, 0, "R7 refused write left no trace");
      access(1, 2'd2, 12'h080, 32'h1234_5678, 0, 0, "R11 task prio write");
      access(0, 2'd2, 12'h080, 0, 32'h1234_5678, 0, "R11 task prio read");
      access(0, 2'd0, 12'h081, 0, 32'h0000_0056, 0, "R7 byte lane 1");
      access(0, 2'd0, 12'h083, 0, 32'h0000_0012, 0, "R7 byte lane 3");
      access(0, 2'd1, 12'h080, 0, 32'd0, 1, "R7 half read refused");
      access(0, 2'd3, 12'h080, 0, 32'd0, 1, "R7 reserved size refused");
      access(1, 2'd2, 12'h020, 32'h0700_0000, 0, 0, "R11 id write");
      access(0, 2'd2, 12'h020, 0, 32'h0700_0000, 0, "R11 id read");
      access(1, 2'd2, 12'h3E0, 32'h0000_000B, 0, 0, "R11 divider write");
      access(0, 2'd2, 12'h3E0, 0, 32'h0000_000B, 0, "R11 divider read");
      access(1, 2'd2, 12'h350, 32'h0000_0741, 0, 0, "R11 vector entry write");
      access(0, 2'd2, 12'h350, 0, 32'h0000_0741, 0, "R11 vector entry read");
      access(1, 2'd2, 12'h530, 32'h0001_00EE, 0, 0, "R11 extended entry write");
      access(0, 2'd2, 12'h530, 0, 32'h0001_00EE, 0, "R11 extended entry read");

      // R8 end of interrupt
      access(1, 2'd2, 12'h0B0, 32'd0, 0, 0, "R8 eoi write");
      check(seen_eoi == 1'b1, "R8 eoi strobe", 32'(seen_eoi), 32'd1);
      @(negedge clk);
      check(!eoi_pulse, "R8 eoi strobe one cycle", 32'(eoi_pulse), 32'd0);
      access(0, 2'd2, 12'h0B0, 0, 32'd0, 0, "R8 eoi read");
      check(seen_eoi == 1'b0, "R8 no strobe on read", 32'(seen_eoi), 32'd0);

      // R9 timer reload: strobe and both counts in one cycle
      access(1, 2'd2, 12'h380, 32'd1000, 0, 0, "R9 initial count write");
      check(seen_load && tmr_count_init == 32'd1000 && tmr_count_cur == 32'd1000,
            "R9 reload same cycle", tmr_count_cur, 32'd1000);
      access(1, 2'd2, 12'h390, 32'd7, 0, 0, "R9 current count write");
      check(!seen_load && tmr_count_init == 32'd1000 && tmr_count_cur == 32'd7,
            "R9 current only", tmr_count_init, 32'd1000);
      access(0, 2'd2, 12'h380, 0, 32'd1000, 0, "R9 initial count read");
      access(0, 2'd2, 12'h390, 0, 32'd7, 0, "R9 current count read");

      // R10 error reporting
      access(0, 2'd2, 12'h300, 0, 32'd0, 1, "R10 command read");
      access(1, 2'd2, 12'h310, 32'd5, 0, 1, "R10 command write");
      access(1, 2'd2, 12'h410, 32'd5, 0, 1, "R10 ext command write");
      access(0, 2'd2, 12'h420, 0, 32'd0, 1, "R10 specific eoi read");
      access(0, 2'd2, 12'h400, 0, 32'd0, 1, "R10 feature read");
      access(0, 2'd2, 12'h5F0, 0, 32'd0, 1, "R10 undecoded read");
      access(0, 2'd2, 12'h028, 0, 32'd0, 1, "R10 offset inside gap");
      access(1, 2'd2, 12'h022, 32'd9, 0, 1, "R10 misaligned write");
      access(0, 2'd2, 12'h020, 0, 32'h0700_0000, 0, "R10 misaligned write no effect");

      // R3 global enable gate against action writes
      ctl_enable = 1'b0;
      access(1, 2'd2, 12'h480, 32'd0, 0, 1, "R3 enable write refused");
      access(1, 2'd2, 12'h0B0, 32'd0, 0, 1, "R3 eoi refused");
      check(!seen_eoi, "R3 no eoi strobe", 32'(seen_eoi), 32'd0);
      access(1, 2'd2, 12'h380, 32'd55, 0, 1, "R3 reload refused");
      check(!seen_load && tmr_count_init == 32'd1000, "R3 no reload", tmr_count_init, 32'd1000);
      access(0, 2'd2, 12'h030, 0, 32'd0, 1, "R3 read refused");
      ctl_enable = 1'b1;
      access(0, 2'd2, 12'h480, 0, 32'h0000_FF00, 0, "R3 enable word unchanged");

      repeat (3) @(negedge clk);
      check(sb.size() == 0, "R2 every access answered", 32'(sb.size()), 32'd0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule